// File: doc/BRIEF.md
# Fractional Fixed-Point Multiplier

This block multiplies signed fractional numbers held in 1.31 and 1.15 form. A four-bit mode code picks which operand parts go into the product (whole words, or one halfword of a source sign-extended to a word) and how wide the result is (one 32-bit word or a 64-bit pair). A separate `frac_n` bit asks for the fractional scaling. It adds the extra left shift by one that keeps the binary point in place when two fractions are multiplied. In the halfword-by-halfword modes it also turns the one product that cannot be represented, minus one times minus one, into the largest positive value. Two modes round to a 16-bit fraction: they add half of the kept LSB and then clear the low halfword.

Operations enter on `in_valid` and leave on `out_valid` two clock cycles later, in issue order, one per cycle. With each result the block updates an overflow flag and an advance-overflow flag. Each of these has a sticky partner that only a reset clears. Between results every output holds its last value.

Top module: `qmul_unit`

## Requirements
- R1: Mode 0 (word by word, one-word result): with frac_n=0 res_lo is bits 63..32 of the signed 64-bit product; with frac_n=1 it is bits 62..31.
- R2: Mode 1 (word by word, two-word result): {res_hi,res_lo} is the signed product, shifted left by one when frac_n=1.
- R3: Modes 2 and 4 use the sign-extended low halfword of opb (bits 15..0), and modes 3 and 5 use the sign-extended high halfword (bits 31..16), each times the whole of opa. Modes 2 and 3 give res_lo = product bits 47..16 (frac_n=0) or 46..15 (frac_n=1). Modes 4 and 5 give the 64-bit product, shifted left by one when frac_n=1.
- R4: flag_v is 0 when frac_n=0. When frac_n=1 in modes 0 to 5 it is 1 exactly when the result word equals 0x80000000: res_hi in modes 1, 4 and 5, res_lo otherwise. flag_sv becomes and stays 1 once any result sets flag_v.
- R5: Modes 6 (low halfwords of both sources) and 7 (high halfwords of both) give res_lo = product shifted left by frac_n. When frac_n=1 a value of 0x80000000 becomes 0x7FFFFFFF. flag_v is 0 in modes 6 to 9.
- R6: Modes 8 (low halfwords) and 9 (high halfwords) add 0x8000 to the mode-6/7 value before its saturation. When frac_n=1 a sum of 0x80008000 becomes 0x7FFF7FFF. res_lo keeps bits 31..16 of that value, and its bits 15..0 are zero.
- R7: flag_av is bit 31 XOR bit 30 of res_hi in modes 1, 4 and 5, and otherwise of the 32-bit result taken before the low halfword is cleared. flag_sav becomes and stays 1 once any result sets flag_av.
- R8: out_valid is high in the second cycle after an accepted operation, for one cycle per operation, in issue order.
- R9: Mode codes 10 to 15 are ignored: no out_valid, and results and flags stay unchanged.
- R10: After reset out_valid, res_lo, res_hi and all four flags are 0.
- R11: In modes 0, 2, 3 and 6 to 9 res_hi is 0.
- R12: While out_valid is low, res_lo, res_hi and all flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 4 | Operand selection and result width code |
| frac_n | input | 1 | Fractional left shift by one |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe |
| res_lo | output | 32 | Result low word, or 32-bit result |
| res_hi | output | 32 | Result high word in two-word modes |
| flag_v | output | 1 | Overflow of last result |
| flag_sv | output | 1 | Sticky overflow |
| flag_av | output | 1 | Advance overflow of last result |
| flag_sav | output | 1 | Sticky advance overflow |

## Verification
The assertions check on every cycle that each sticky flag covers its live flag and never falls. They also check that outputs hold while no result is presented, that out_valid traces back to a legal operation two cycles earlier, that rounded results have a clear low halfword, that halfword modes never raise overflow, and that one-word modes leave res_hi at zero. Only the bench's scenarios can show that the arithmetic is right: the bit windows chosen by each mode and shift, the minus-one-squared saturation, the rounding carry, and the advance flag on the proper word. These are compared against a 64-bit reference product over every corner pairing of 0x8000, 0x80000000, zero and minus one, and over random operands.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

    typedef enum logic [3:0] {
        QM_W32  = 4'd0,
        QM_W64  = 4'd1,
        QM_BL32 = 4'd2,
        QM_BU32 = 4'd3,
        QM_BL64 = 4'd4,
        QM_BU64 = 4'd5,
        QM_HLL  = 4'd6,
        QM_HUU  = 4'd7,
        QM_RLL  = 4'd8,
        QM_RUU  = 4'd9
    } qmode_e;

    localparam logic [3:0] QM_LAST = 4'd9;

    function automatic logic mode_ok(input logic [3:0] m);
        return m <= QM_LAST;
    endfunction

    function automatic logic mode_wide(input logic [3:0] m);
        return (m == QM_W64) || (m == QM_BL64) || (m == QM_BU64);
    endfunction

endpackage

// File: rtl/qmul_opsel.sv
module qmul_opsel
    import qmul_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]           mode,
    input  logic [DW-1:0]        src_a,
    input  logic [DW-1:0]        src_b,
    output logic signed [DW-1:0] op_a,
    output logic signed [DW-1:0] op_b
);
    localparam int HW = DW / 2;

    logic signed [DW-1:0] a_lo, a_up, b_lo, b_up;

    always_comb begin
        a_lo = DW'($signed(src_a[HW-1:0]));
        a_up = DW'($signed(src_a[DW-1:HW]));
        b_lo = DW'($signed(src_b[HW-1:0]));
        b_up = DW'($signed(src_b[DW-1:HW]));
        case (mode)
            QM_HLL, QM_RLL: op_a = a_lo;
            QM_HUU, QM_RUU: op_a = a_up;
            default:        op_a = $signed(src_a);
        endcase
        case (mode)
            QM_BL32, QM_BL64, QM_HLL, QM_RLL: op_b = b_lo;
            QM_BU32, QM_BU64, QM_HUU, QM_RUU: op_b = b_up;
            default:                          op_b = $signed(src_b);
        endcase
    end
endmodule

// File: rtl/qmul_post.sv
module qmul_post
    import qmul_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]      mode,
    input  logic            frac_n,
    input  logic [2*DW-1:0] prod,
    output logic [DW-1:0]   lo,
    output logic [DW-1:0]   hi,
    output logic            ovf,
    output logic            adv
);
    localparam int HW = DW / 2;
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] MIN_W    = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_W    = ~MIN_W;
    localparam logic [DW-1:0] HALF_LSB = DW'(1) << (HW - 1);
    localparam logic [DW-1:0] RND_TRIP = {1'b1, {(HW-1){1'b0}}, 1'b1, {(HW-1){1'b0}}};
    localparam logic [DW-1:0] RND_SAT  = {1'b0, {(HW-1){1'b1}}, 1'b0, {(HW-1){1'b1}}};

    logic [PW-1:0] wide_w;
    logic [DW-1:0] full_w, part_w, half_w, rnd_w, pre_w;

    always_comb begin
        wide_w = frac_n ? {prod[PW-2:0], 1'b0} : prod;
        full_w = frac_n ? prod[PW-2:DW-1] : prod[PW-1:DW];
        part_w = frac_n ? prod[DW+HW-2:HW-1] : prod[DW+HW-1:HW];
        half_w = frac_n ? {prod[DW-2:0], 1'b0} : prod[DW-1:0];
        rnd_w  = half_w + HALF_LSB;
        hi     = '0;
        lo     = '0;
        pre_w  = '0;
        ovf    = 1'b0;
        case (mode)
            QM_W64, QM_BL64, QM_BU64: begin
                hi  = wide_w[PW-1:DW];
                lo  = wide_w[DW-1:0];
                ovf = frac_n && (wide_w[PW-1:DW] == MIN_W);
            end
            QM_W32: begin
                pre_w = full_w;
                lo    = full_w;
                ovf   = frac_n && (full_w == MIN_W);
            end
            QM_BL32, QM_BU32: begin
                pre_w = part_w;
                lo    = part_w;
                ovf   = frac_n && (part_w == MIN_W);
            end
            QM_HLL, QM_HUU: begin
                pre_w = (frac_n && (half_w == MIN_W)) ? MAX_W : half_w;
                lo    = pre_w;
            end
            QM_RLL, QM_RUU: begin
                pre_w = (frac_n && (rnd_w == RND_TRIP)) ? RND_SAT : rnd_w;
                lo    = {pre_w[DW-1:HW], {HW{1'b0}}};
            end
            default: ;
        endcase
        adv = mode_wide(mode) ? (hi[DW-1] ^ hi[DW-2]) : (pre_w[DW-1] ^ pre_w[DW-2]);
    end
endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
    import qmul_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    mode,
    input  logic          frac_n,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic          out_valid,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          flag_v,
    output logic          flag_sv,
    output logic          flag_av,
    output logic          flag_sav
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic          s1_vld;
        logic [3:0]    s1_mode;
        logic          s1_n;
        logic [PW-1:0] s1_prod;
        logic          o_vld;
        logic [DW-1:0] o_lo;
        logic [DW-1:0] o_hi;
        logic          o_v;
        logic          o_av;
        logic          o_sv;
        logic          o_sav;
    } qst_t;

    qst_t st_d, st_q;

    logic signed [DW-1:0] op_a, op_b;
    logic signed [PW-1:0] ext_a, ext_b, prod_c;
    logic [DW-1:0]        post_lo, post_hi;
    logic                 post_v, post_av;

    qmul_opsel #(.DW(DW)) u_opsel (
        .mode  (mode),
        .src_a (opa),
        .src_b (opb),
        .op_a  (op_a),
        .op_b  (op_b)
    );

    assign ext_a  = PW'(op_a);
    assign ext_b  = PW'(op_b);
    assign prod_c = ext_a * ext_b;

    qmul_post #(.DW(DW)) u_post (
        .mode   (st_q.s1_mode),
        .frac_n (st_q.s1_n),
        .prod   (st_q.s1_prod),
        .lo     (post_lo),
        .hi     (post_hi),
        .ovf    (post_v),
        .adv    (post_av)
    );

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = in_valid && mode_ok(mode);
        if (st_d.s1_vld) begin
            st_d.s1_mode = mode;
            st_d.s1_n    = frac_n;
            st_d.s1_prod = prod_c;
        end
        st_d.o_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.o_lo  = post_lo;
            st_d.o_hi  = post_hi;
            st_d.o_v   = post_v;
            st_d.o_av  = post_av;
            st_d.o_sv  = st_q.o_sv | post_v;
            st_d.o_sav = st_q.o_sav | post_av;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o_vld;
    assign res_lo    = st_q.o_lo;
    assign res_hi    = st_q.o_hi;
    assign flag_v    = st_q.o_v;
    assign flag_sv   = st_q.o_sv;
    assign flag_av   = st_q.o_av;
    assign flag_sav  = st_q.o_sav;
endmodule

// File: rtl/qmul_chk.sv
module qmul_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    mode,
    input logic          frac_n,
    input logic          out_valid,
    input logic [DW-1:0] res_lo,
    input logic [DW-1:0] res_hi,
    input logic          flag_v,
    input logic          flag_sv,
    input logic          flag_av,
    input logic          flag_sav
);
    localparam int HW = DW / 2;

    // R8 R9
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid, 2) && ($past(mode, 2) <= 4'd9)));

    // R4
    sv_covers_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |-> flag_sv);

    // R4
    sv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(flag_sv));

    // R7
    sav_covers_av_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_av |-> flag_sav);

    // R7
    sav_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(flag_sav));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(res_lo) && $stable(res_hi) && $stable(flag_v) && $stable(flag_av)));

    // R6
    round_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (($past(mode, 2) == 4'd8) || ($past(mode, 2) == 4'd9)))
        |-> (res_lo[HW-1:0] == '0));

    // R5
    half_no_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(mode, 2) >= 4'd6)) |-> !flag_v);

    // R4
    plain_no_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(frac_n, 2)) |-> !flag_v);

    // R11
    narrow_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(mode, 2) != 4'd1) && ($past(mode, 2) != 4'd4)
         && ($past(mode, 2) != 4'd5)) |-> (res_hi == '0));
endmodule

bind qmul_unit qmul_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .frac_n    (frac_n),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .flag_v    (flag_v),
    .flag_sv   (flag_sv),
    .flag_av   (flag_av),
    .flag_sav  (flag_sav)
);

// File: tb/sim_qmul_unit.sv
module sim_qmul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic        frac_n = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] res_lo, res_hi;
    logic        flag_v, flag_sv, flag_av, flag_sav;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        logic        v;
        logic        av;
        logic        sv;
        logic        sav;
        logic [3:0]  md;
    } exp_t;

    exp_t exp_q[$];
    logic m_sv = 1'b0;
    logic m_sav = 1'b0;

    always #2 clk = ~clk;

    qmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .frac_n(frac_n),
        .opa(opa), .opb(opb), .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
        .flag_v(flag_v), .flag_sv(flag_sv), .flag_av(flag_av), .flag_sav(flag_sav)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [3:0] m);
        case (m)
            4'd0:                 return "R1";
            4'd1:                 return "R2";
            4'd2, 4'd3, 4'd4, 4'd5: return "R3";
            4'd6, 4'd7:           return "R5";
            default:              return "R6";
        endcase
    endfunction

    function automatic exp_t ref_op(input logic [3:0] m, input logic n,
                                    input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        longint sa, sb, p;
        logic [63:0] r;
        logic [31:0] t, pre;
        logic wide;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (m == 4'd2 || m == 4'd4) sb = longint'($signed(b[15:0]));
        if (m == 4'd3 || m == 4'd5) sb = longint'($signed(b[31:16]));
        if (m == 4'd6 || m == 4'd8) begin
            sa = longint'($signed(a[15:0])); sb = longint'($signed(b[15:0]));
        end
        if (m == 4'd7 || m == 4'd9) begin
            sa = longint'($signed(a[31:16])); sb = longint'($signed(b[31:16]));
        end
        p = sa * sb;
        wide = (m == 4'd1 || m == 4'd4 || m == 4'd5);
        e.hi = '0; e.v = 1'b0; e.md = m;
        pre = '0;
        if (wide) begin
            r = 64'(p <<< n);
            e.lo = r[31:0]; e.hi = r[63:32];
            e.v = n && (e.hi == 32'h80000000);
        end else if (m == 4'd0 || m == 4'd2 || m == 4'd3) begin
            r = 64'(p >>> ((m == 4'd0 ? 32 : 16) - int'(n)));
            pre = r[31:0]; e.lo = pre;
            e.v = n && (pre == 32'h80000000);
        end else if (m == 4'd6 || m == 4'd7) begin
            t = 32'(p <<< n);
            if (n && t == 32'h80000000) t = 32'h7FFFFFFF;
            pre = t; e.lo = t;
        end else begin
            t = 32'(p <<< n) + 32'h00008000;
            if (n && t == 32'h80008000) t = 32'h7FFF7FFF;
            pre = t; e.lo = {t[31:16], 16'h0000};
        end
        e.av = wide ? (e.hi[31] ^ e.hi[30]) : (pre[31] ^ pre[30]);
        e.sv = 1'b0; e.sav = 1'b0;
        return e;
    endfunction

    task automatic issue(input logic [3:0] m, input logic n,
                         input logic [31:0] a, input logic [31:0] b);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; mode = m; frac_n = n; opa = a; opb = b;
        if (m <= 4'd9) begin
            e = ref_op(m, n, a, b);
            m_sv  = m_sv | e.v;
            m_sav = m_sav | e.av;
            e.sv  = m_sv;
            e.sav = m_sav;
            exp_q.push_back(e);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 R9 unexpected out_valid", 64'(out_valid), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({mode_tag(e.md), " res_lo"}, 64'(res_lo), 64'(e.lo));
                check(((e.md == 4'd1 || e.md == 4'd4 || e.md == 4'd5) ? "R2 R3 res_hi" : "R11 res_hi"),
                      64'(res_hi), 64'(e.hi));
                check("R4 flag_v", 64'(flag_v), 64'(e.v));
                check("R4 flag_sv", 64'(flag_sv), 64'(e.sv));
                check("R7 flag_av", 64'(flag_av), 64'(e.av));
                check("R7 flag_sav", 64'(flag_sav), 64'(e.sav));
            end
        end
    end

    logic [31:0] corner [8] = '{32'h80000000, 32'h00008000, 32'h80008000, 32'h00000000,
                                32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00010000, 32'hFFFF8000};

    initial begin
        logic [31:0] s_lo, s_hi;
        logic [3:0]  s_fl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 64'(out_valid), 64'd0);
        check("R10 res_lo", 64'(res_lo), 64'd0);
        check("R10 res_hi", 64'(res_hi), 64'd0);
        check("R10 flags", 64'({flag_v, flag_sv, flag_av, flag_sav}), 64'd0);

        // R8 latency: one op, out_valid low after one edge, high after two
        issue(4'd6, 1'b0, 32'h00004000, 32'h00002000);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 latency cycle 1", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R8 latency cycle 2", 64'(out_valid), 64'd1);
        idle(3);

        // R9 R12: reserved code leaves everything unchanged
        s_lo = res_lo; s_hi = res_hi;
        s_fl = {flag_v, flag_sv, flag_av, flag_sav};
        issue(4'd12, 1'b1, 32'h80000000, 32'h80000000);
        issue(4'd15, 1'b1, 32'h00008000, 32'h00008000);
        idle(4);
        check("R9 R12 res_lo held", 64'(res_lo), 64'(s_lo));
        check("R9 R12 res_hi held", 64'(res_hi), 64'(s_hi));
        check("R9 R12 flags held", 64'({flag_v, flag_sv, flag_av, flag_sav}), 64'(s_fl));

        // directed minus-one squared cases, halfword and word
        issue(4'd6, 1'b1, 32'h00008000, 32'h00008000);
        issue(4'd8, 1'b1, 32'h00008000, 32'h00008000);
        issue(4'd9, 1'b0, 32'h40000000, 32'h40000000);
        issue(4'd0, 1'b1, 32'h80000000, 32'h80000000);
        issue(4'd1, 1'b1, 32'h80000000, 32'h80000000);
        idle(4);

        // corner sweep, back to back
        for (int m = 0; m < 10; m++)
            for (int n = 0; n < 2; n++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        issue(4'(m), 1'(n), corner[i], corner[j]);
        idle(4);

        // random operands with occasional gaps
        for (int k = 0; k < 600; k++) begin
            issue(4'($urandom_range(0, 9)), 1'($urandom_range(0, 1)), $urandom, $urandom);
            if ($urandom_range(0, 7) == 0) idle(1);
        end
        idle(5);
        check("R8 all results delivered", 64'(exp_q.size()), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule